// File: doc/BRIEF.md
# Multi-Mode Operand Resolver

This block works out the operand for one instruction operand that may live in memory. The caller presents a mode code together with the instruction's fields: a base register number, the contents of the base and index registers, a signed displacement or absolute-address field, an immediate field, and an operand-size code. A one-cycle `start` pulse launches the operation. The block then computes the effective address and, when the mode needs it, reads memory through a request/acknowledge port. It returns the operand value and the effective address, and reports any base-register update on a write-back port.

Register and immediate modes complete one cycle after `start` and never touch memory. Memory-indirect mode makes two dependent reads: the first fetches a pointer and the second fetches the operand. Auto-increment and auto-decrement modes read at the base address, then step the base register by the operand size. The write-back is issued together with the operand-valid pulse. Every address sum wraps modulo 2^32.

Top module: `operand_resolver`

## Requirements
- R1: The mode codes are 0 register, 1 immediate, 2 displacement, 3 register indirect, 4 indexed, 5 direct, 6 memory indirect, 7 auto-increment, 8 auto-decrement and 9 scaled. Codes 10 to 15 behave as register mode. Modes 0, 1 and 10 to 15 raise `done` in the cycle after `start` and make no memory request. The operand is `base_val` (or `imm` for code 1), and `ea` is 0.
- R2: The effective address, modulo 2^32, is `base_val+disp` for displacement, `base_val` for register indirect, `base_val+index_val` for indexed, and `disp` for direct. The operand is the memory word read at that address.
- R3: For scaled mode the address is `disp + base_val + (index_val << size_log2)`, modulo 2^32.
- R4: Memory-indirect mode makes exactly two reads. The first is at `base_val` and returns a pointer. The second is at that pointer and returns the operand, and `ea` reports the pointer.
- R5: Auto-increment and auto-decrement read at `base_val`. In the cycle where `done` is high they pulse `wb_en` exactly once, with `wb_idx = base_idx` and `wb_data = base_val ± (1 << size_log2)`, modulo 2^32. No other mode raises `wb_en`.
- R6: `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is sampled high. Every mode except memory indirect makes at most one read.
- R7: `busy` is high from the cycle after `start` until the operation finishes and is low in the `done` cycle. A `start` that arrives while `busy` is high is ignored.
- R8: After reset, `busy`, `done`, `mem_req` and `wb_en` are low, and `operand` and `ea` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (taken when not busy) |
| mode | input | 4 | Addressing mode code |
| base_idx | input | RIW | Base register number, used for write-back |
| base_val | input | XLEN | Base register contents |
| index_val | input | XLEN | Index register contents |
| disp | input | XLEN | Displacement or absolute address field |
| imm | input | XLEN | Immediate field |
| size_log2 | input | 2 | Operand size d = 1 << size_log2 bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle operand-valid pulse |
| operand | output | XLEN | Resolved operand |
| ea | output | XLEN | Effective address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | XLEN | Memory read address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_rdata | input | XLEN | Memory read data |
| wb_en | output | 1 | Base register write-back strobe |
| wb_idx | output | RIW | Register to write |
| wb_data | output | XLEN | Updated base value |

## Verification
On every cycle the assertions check four things. A request holds its address until it is acknowledged. `wb_en` appears only alongside `done` and never two cycles in a row. Register and immediate modes finish in the next cycle. No request is pending when `done` rises. The bench sweeps every mode code, every operand size and several memory latencies, and compares the operand, the address, the number of reads, the first read address and the write-back against arithmetic it computes itself. It also covers wrap-around bases and a start that arrives while busy, which only those scenarios can show.

// File: rtl/operand_resolver.sv
module operand_resolver #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [RIW-1:0]  base_idx,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  input  logic [XLEN-1:0] disp,
  input  logic [XLEN-1:0] imm,
  input  logic [1:0]      size_log2,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] ea,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            wb_en,
  output logic [RIW-1:0]  wb_idx,
  output logic [XLEN-1:0] wb_data
);
  localparam logic [3:0] M_IMM = 4'd1, M_DISP = 4'd2, M_RIND = 4'd3, M_IDX = 4'd4,
                         M_DIR = 4'd5, M_MIND = 4'd6, M_AINC = 4'd7, M_ADEC = 4'd8,
                         M_SCL = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2} state_t;
  state_t state;
  logic indirect, do_wb;
  logic [XLEN-1:0] addr_calc, step;

  wire is_mem = (mode >= M_DISP) && (mode <= M_SCL);
  assign step = XLEN'(1) << size_log2;
  assign busy = (state != S_IDLE);
  assign mem_req = busy;

  always_comb begin
    case (mode)
      M_DISP:  addr_calc = base_val + disp;
      M_IDX:   addr_calc = base_val + index_val;
      M_DIR:   addr_calc = disp;
      M_SCL:   addr_calc = disp + base_val + (index_val << size_log2);
      default: addr_calc = base_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      wb_en    <= 1'b0;
      operand  <= '0;
      ea       <= '0;
      mem_addr <= '0;
      indirect <= 1'b0;
      do_wb    <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (is_mem) begin
            mem_addr <= addr_calc;
            indirect <= (mode == M_MIND);
            do_wb    <= (mode == M_AINC) || (mode == M_ADEC);
            wb_idx   <= base_idx;
            wb_data  <= (mode == M_ADEC) ? base_val - step : base_val + step;
            state    <= S_RD1;
          end else begin
            operand <= (mode == M_IMM) ? imm : base_val;
            ea      <= '0;
            done    <= 1'b1;
          end
        end
        default: if (mem_ack) begin
          if (state == S_RD1 && indirect) begin
            mem_addr <= mem_rdata;
            state    <= S_RD2;
          end else begin
            operand <= mem_rdata;
            ea      <= mem_addr;
            done    <= 1'b1;
            wb_en   <= do_wb;
            state   <= S_IDLE;
          end
        end
      endcase
    end
  end

  assert_hold_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  assert_wb_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  assert_wb_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);
  assert_fast_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !is_mem |=> done && !mem_req);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

// File: tb/test_operand_resolver.sv
module test_operand_resolver;
  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] mode = 0;
  logic [2:0] base_idx = 0;
  logic [31:0] base_val = 0, index_val = 0, disp = 0, imm = 0;
  logic [1:0] size_log2 = 0;
  logic busy, done, mem_req, mem_ack = 0, wb_en;
  logic [31:0] operand, ea, mem_addr, mem_rdata = 0, wb_data;
  logic [2:0] wb_idx;
  int ntests = 0, nfail = 0, lat = 0, cnt = 0, nacks = 0;
  logic [31:0] first_addr = 0;

  always #10 clk = ~clk;

  operand_resolver i_operand_resolver (.*);

  function automatic logic [31:0] fmem(input logic [31:0] a);
    return (a * 32'h0001_9E37) ^ 32'h5A5A_1234;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin mem_ack = 0; cnt = 0; end
    else if (mem_ack) begin mem_ack = 0; cnt = 0; end
    else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack = 1; mem_rdata = fmem(mem_addr);
        if (nacks == 0) first_addr = mem_addr;
        nacks++;
      end else cnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [2:0] bi, input logic [31:0] bv,
                        input logic [31:0] iv, input logic [31:0] dv, input logic [31:0] im,
                        input logic [1:0] sz, input int lt, input bit poke);
    logic [31:0] addr, ptr, exp_op, exp_ea;
    int exp_acks, cyc;
    bit memop, wb;
    memop = (m >= 2) && (m <= 9);
    wb = (m == 7) || (m == 8);
    @(negedge clk);
    mode = m; base_idx = bi; base_val = bv; index_val = iv; disp = dv; imm = im;
    size_log2 = sz; lat = lt; nacks = 0; start = 1;
    @(negedge clk);
    start = 0;
    if (memop) check("R7 busy after start", {31'b0, busy}, 1);
    else check("R1 done next cycle", {31'b0, done}, 1);
    if (poke && memop) begin
      mode = 4'd1; imm = 32'hDEAD_BEEF; start = 1;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    check("R7 completion", {31'b0, done}, 1);
    case (m)
      4'd2: addr = bv + dv;
      4'd4: addr = bv + iv;
      4'd5: addr = dv;
      4'd9: addr = dv + bv + (iv << sz);
      default: addr = bv;
    endcase
    exp_acks = 0;
    if (!memop) begin exp_op = (m == 1) ? im : bv; exp_ea = 0; end
    else if (m == 6) begin
      ptr = fmem(bv); exp_op = fmem(ptr); exp_ea = ptr; exp_acks = 2;
    end else begin exp_op = fmem(addr); exp_ea = addr; exp_acks = 1; end
    check(memop ? (m == 6 ? "R4 operand" : (m == 9 ? "R3 operand" : "R2 operand")) : "R1 operand",
          operand, exp_op);
    check(m == 9 ? "R3 ea" : (m == 6 ? "R4 ea" : "R2 ea"), ea, exp_ea);
    check("R6 read count", nacks, exp_acks);
    if (memop) check("R6 first read addr", first_addr, (m == 6) ? bv : addr);
    check("R7 busy low at done", {31'b0, busy}, 0);
    check("R5 wb_en", {31'b0, wb_en}, {31'b0, wb});
    if (wb) begin
      check("R5 wb_idx", {29'b0, wb_idx}, {29'b0, bi});
      check("R5 wb_data", wb_data, (m == 8) ? bv - (32'd1 << sz) : bv + (32'd1 << sz));
    end
    @(negedge clk);
    check("R5 single wb", {31'b0, wb_en}, 0);
    check("R7 single done", {31'b0, done}, 0);
  endtask

  initial begin
    #(20ns * 200000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1000; bases[1] = 32'hFFFF_FFFC; bases[2] = 32'h0;
    repeat (3) @(negedge clk);
    check("R8 busy", {31'b0, busy}, 0);
    check("R8 done", {31'b0, done}, 0);
    check("R8 mem_req", {31'b0, mem_req}, 0);
    check("R8 wb_en", {31'b0, wb_en}, 0);
    check("R8 operand", operand, 0);
    check("R8 ea", ea, 0);
    rst_n = 1;
    for (int m = 0; m <= 10; m++)
      for (int s = 0; s < 4; s++)
        for (int l = 0; l < 3; l++)
          for (int b = 0; b < 3; b++)
            run_op(4'(m), 3'(m + b), bases[b], 32'h4000_0001 + 32'(s), 32'hFFFF_FF80 + 32'(l),
                   32'h0BAD_0000 + 32'(m), 2'(s), l, 1'b0);
    run_op(4'd15, 3'd2, 32'h1234_5678, 0, 0, 32'h1, 2'd0, 0, 1'b0);
    run_op(4'd6, 3'd1, 32'h0000_2000, 0, 0, 0, 2'd2, 2, 1'b1);
    run_op(4'd8, 3'd0, 32'h0000_0002, 0, 0, 0, 2'd3, 1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule